// File: doc/BRIEF.md
# Serial bank window address mapper

This block lets a secondary processor reach any 32 KB-aligned region of a 24-bit main bus through a fixed 32 KB window in its own address space. The window's main-bus base is loaded serially: every write to the single bank-select register contributes one bit, taken from bit 0 of the written byte. That bit enters the base at its most significant position while the older bits move one place down. After nine writes, the nine bits written so far, oldest in the lowest position, form the upper bits of the base.

An access to the window presents a 15-bit offset with a read or write strobe. The mapper issues the main-bus address, base plus offset, one clock later. The strobes and write data are registered alongside the address, so all of them change in the same cycle. Read data from the main bus returns to the window port combinationally and unchanged. Bus ownership, wait states and main-bus timing belong to other blocks.

Top module: `bank_window_mapper`

## Requirements
- R1: After synchronous reset the base is zero, `mb_rd` and `mb_wr` are low, and the first window access maps offset N to main-bus address N.
- R2: Each cycle with `bank_we` high shifts base bits 23..15 right by one place and loads the written bit into base bit 23. Base bits 14..0 are always zero.
- R3: Only bit 0 of `bank_wdata` affects the base; bits 7..1 have no effect.
- R4: Nine consecutive bank writes of a 9-bit pattern P, least significant bit first, give a base of P shifted left by 15 (P × 0x8000).
- R5: One cycle after a window access, `mb_addr` equals base + `win_off` (the 15-bit offset) and `mb_wdata` equals the written data. `mb_rd` and `mb_wr` repeat `win_rd` and `win_wr` in that same cycle.
- R6: `win_rdata` always equals `mb_rdata` in the same cycle.
- R7: A window access in the same cycle as a bank write is translated with the base as it was before that write.
- R8: In the cycle after a cycle with no window strobe, `mb_rd` and `mb_wr` are low and `mb_addr` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_we | input | 1 | Bank-select register write strobe |
| bank_wdata | input | 8 | Bank-select write data (bit 0 used) |
| win_rd | input | 1 | Window read strobe |
| win_wr | input | 1 | Window write strobe |
| win_off | input | 15 | Offset within the 32 KB window |
| win_wdata | input | 8 | Window write data |
| win_rdata | output | 8 | Window read data returned from the main bus |
| mb_addr | output | 24 | Translated main-bus address |
| mb_rd | output | 1 | Main-bus read strobe |
| mb_wr | output | 1 | Main-bus write strobe |
| mb_wdata | output | 8 | Main-bus write data |
| mb_rdata | input | 8 | Main-bus read data |

## Verification
The bench loads every one of the 512 nine-bit patterns serially. Each load puts arbitrary values in the ignored upper data bits. Each resulting base is then read back through accesses at the lowest offset, the highest offset and a patterned offset. These three offsets separate a correct base from one that has shifted the wrong way or picked up a stray carry. Single writes onto known bases show the one-place shift and the insertion at the top bit. A window access in the same cycle as a bank write shows which base the translation uses. Idle cycles show that the strobes drop and the address holds.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  localparam int MAIN_AW_DEF = 24;
  localparam int WIN_AW_DEF  = 15;
  localparam int DW_DEF      = 8;

  typedef struct packed {
    logic rd;
    logic wr;
  } strobe_t;
endpackage

// File: rtl/bwm_bank_shift.sv
module bwm_bank_shift #(
  parameter int MAIN_AW = 24,
  parameter int WIN_AW  = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic               shift_bit,
  output logic [MAIN_AW-1:0] base_o
);
  localparam int BANK_BITS = MAIN_AW - WIN_AW;

  logic [BANK_BITS-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
    end else if (shift_en) begin
      bank_q <= {shift_bit, bank_q[BANK_BITS-1:1]};
    end
  end

  assign base_o = {bank_q, {WIN_AW{1'b0}}};
endmodule

// File: rtl/bwm_xlate.sv
module bwm_xlate
  import bwm_pkg::*;
#(
  parameter int MAIN_AW   = 24,
  parameter int WIN_AW    = 15,
  parameter int DW        = 8,
  parameter bit USE_ADDER = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [MAIN_AW-1:0] base_i,
  input  strobe_t            req_i,
  input  logic [WIN_AW-1:0]  off_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [MAIN_AW-1:0] addr_o,
  output strobe_t            stb_o,
  output logic [DW-1:0]      wdata_o
);
  localparam int BANK_BITS = MAIN_AW - WIN_AW;

  logic [MAIN_AW-1:0] addr_next;

  generate
    if (USE_ADDER) begin : g_add
      assign addr_next = base_i + {{BANK_BITS{1'b0}}, off_i};
    end else begin : g_cat
      logic [WIN_AW-1:0] unused_low;
      assign unused_low = base_i[WIN_AW-1:0];
      assign addr_next  = {base_i[MAIN_AW-1:WIN_AW], off_i};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      stb_o   <= '0;
      wdata_o <= '0;
    end else begin
      stb_o <= req_i;
      if (req_i.rd || req_i.wr) begin
        addr_o  <= addr_next;
        wdata_o <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper
  import bwm_pkg::*;
#(
  parameter int MAIN_AW   = MAIN_AW_DEF,
  parameter int WIN_AW    = WIN_AW_DEF,
  parameter int DW        = DW_DEF,
  parameter bit USE_ADDER = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bank_we,
  input  logic [DW-1:0]      bank_wdata,
  input  logic               win_rd,
  input  logic               win_wr,
  input  logic [WIN_AW-1:0]  win_off,
  input  logic [DW-1:0]      win_wdata,
  output logic [DW-1:0]      win_rdata,
  output logic [MAIN_AW-1:0] mb_addr,
  output logic               mb_rd,
  output logic               mb_wr,
  output logic [DW-1:0]      mb_wdata,
  input  logic [DW-1:0]      mb_rdata
);
  logic [MAIN_AW-1:0] base_w;
  strobe_t            req_w;
  strobe_t            stb_w;
  logic               unused_hi;

  assign unused_hi = ^bank_wdata[DW-1:1];
  assign req_w     = '{rd: win_rd, wr: win_wr};

  bwm_bank_shift #(
    .MAIN_AW(MAIN_AW),
    .WIN_AW (WIN_AW)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (bank_we),
    .shift_bit(bank_wdata[0]),
    .base_o   (base_w)
  );

  bwm_xlate #(
    .MAIN_AW  (MAIN_AW),
    .WIN_AW   (WIN_AW),
    .DW       (DW),
    .USE_ADDER(USE_ADDER)
  ) u_xlate (
    .clk    (clk),
    .rst    (rst),
    .base_i (base_w),
    .req_i  (req_w),
    .off_i  (win_off),
    .wdata_i(win_wdata),
    .addr_o (mb_addr),
    .stb_o  (stb_w),
    .wdata_o(mb_wdata)
  );

  assign mb_rd     = stb_w.rd;
  assign mb_wr     = stb_w.wr;
  assign win_rdata = mb_rdata;
endmodule

// File: rtl/bwm_chk.sv
module bwm_chk #(
  parameter int MAIN_AW = 24,
  parameter int WIN_AW  = 15,
  parameter int DW      = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               bank_we,
  input logic [DW-1:0]      bank_wdata,
  input logic               win_rd,
  input logic               win_wr,
  input logic [WIN_AW-1:0]  win_off,
  input logic [DW-1:0]      win_wdata,
  input logic [DW-1:0]      win_rdata,
  input logic [MAIN_AW-1:0] mb_addr,
  input logic               mb_rd,
  input logic               mb_wr,
  input logic [DW-1:0]      mb_wdata,
  input logic [DW-1:0]      mb_rdata,
  input logic [MAIN_AW-1:0] base
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mb_rd && !mb_wr));

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    bank_we |=> (base[MAIN_AW-1] == $past(bank_wdata[0])) &&
                (base[MAIN_AW-2:WIN_AW] == $past(base[MAIN_AW-1:WIN_AW+1])));

  // R2
  base_align_chk: assert property (@(posedge clk) disable iff (rst)
    base[WIN_AW-1:0] == '0);

  // R2
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bank_we |=> $stable(base));

  // R5
  rd_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    win_rd |=> mb_rd);

  // R5
  wr_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    win_wr |=> mb_wr);

  // R5
  R7_old_base_chk: assert property (@(posedge clk) disable iff (rst)
    (win_rd || win_wr) |=>
      (mb_addr == $past(base) + MAIN_AW'($past(win_off))) &&
      (mb_wdata == $past(win_wdata)));

  // R6
  rdata_pass_chk: assert property (@(posedge clk) disable iff (rst)
    win_rdata == mb_rdata);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(win_rd || win_wr) |=> (!mb_rd && !mb_wr && $stable(mb_addr)));
endmodule

bind bank_window_mapper bwm_chk #(
  .MAIN_AW(MAIN_AW),
  .WIN_AW (WIN_AW),
  .DW     (DW)
) u_bwm_chk (
  .clk       (clk),
  .rst       (rst),
  .bank_we   (bank_we),
  .bank_wdata(bank_wdata),
  .win_rd    (win_rd),
  .win_wr    (win_wr),
  .win_off   (win_off),
  .win_wdata (win_wdata),
  .win_rdata (win_rdata),
  .mb_addr   (mb_addr),
  .mb_rd     (mb_rd),
  .mb_wr     (mb_wr),
  .mb_wdata  (mb_wdata),
  .mb_rdata  (mb_rdata),
  .base      (base_w)
);

// File: tb/test_bank_window_mapper.sv
`timescale 1ns/1ps
module test_bank_window_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bank_we = 1'b0;
  logic [7:0]  bank_wdata = '0;
  logic        win_rd = 1'b0;
  logic        win_wr = 1'b0;
  logic [14:0] win_off = '0;
  logic [7:0]  win_wdata = '0;
  logic [7:0]  win_rdata;
  logic [23:0] mb_addr;
  logic        mb_rd;
  logic        mb_wr;
  logic [7:0]  mb_wdata;
  logic [7:0]  mb_rdata = '0;

  int checks = 0;
  int failures = 0;
  logic [8:0] model = '0;

  always #4 clk = ~clk;

  bank_window_mapper i_bank_window_mapper (
    .clk(clk), .rst(rst), .bank_we(bank_we), .bank_wdata(bank_wdata),
    .win_rd(win_rd), .win_wr(win_wr), .win_off(win_off),
    .win_wdata(win_wdata), .win_rdata(win_rdata), .mb_addr(mb_addr),
    .mb_rd(mb_rd), .mb_wr(mb_wr), .mb_wdata(mb_wdata), .mb_rdata(mb_rdata)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_addr(input logic [14:0] off);
    return (24'(model) * 24'h8000) + 24'(off);
  endfunction

  task automatic bank_write(input logic [7:0] d);
    @(negedge clk);
    bank_we = 1'b1;
    bank_wdata = d;
    @(negedge clk);
    bank_we = 1'b0;
    model = {d[0], model[8:1]};
  endtask

  task automatic access(input logic rd, input logic wr,
                        input logic [14:0] off, input logic [7:0] wd,
                        input string req);
    @(negedge clk);
    win_rd = rd; win_wr = wr; win_off = off; win_wdata = wd;
    @(negedge clk);
    win_rd = 1'b0; win_wr = 1'b0;
    check(req, 32'(mb_addr), 32'(exp_addr(off)));
    check(req, {31'd0, mb_rd}, {31'd0, rd});
    check(req, {31'd0, mb_wr}, {31'd0, wr});
    if (wr) check(req, 32'(mb_wdata), 32'(wd));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [23:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rd low", {31'd0, mb_rd}, 32'd0);
    check("R1 wr low", {31'd0, mb_wr}, 32'd0);
    check("R1 addr zero", 32'(mb_addr), 32'd0);
    access(1'b1, 1'b0, 15'h1234, 8'h00, "R1 first access");

    // R6 read data pass-through
    for (int k = 0; k < 256; k += 17) begin
      mb_rdata = 8'(k);
      #1;
      check("R6 rdata", 32'(win_rdata), 32'(k));
    end

    // R2 single shifts from known bases
    bank_write(8'h01);
    access(1'b1, 1'b0, 15'h0000, 8'h00, "R2 one into top");
    check("R2 base=0x800000", 32'(mb_addr), 32'h800000);
    bank_write(8'h00);
    access(1'b0, 1'b1, 15'h0000, 8'h5A, "R2 shift down");
    check("R2 base=0x400000", 32'(mb_addr), 32'h400000);

    // R3 upper data bits ignored
    bank_write(8'hFE);
    access(1'b1, 1'b0, 15'h0001, 8'h00, "R3 0xFE acts as 0");
    check("R3 base=0x200001", 32'(mb_addr), 32'h200001);

    // R4 full sweep of 9-bit patterns, R5 offsets, R3 noise bits
    for (int p = 0; p < 512; p++) begin
      for (int b = 0; b < 9; b++) begin
        logic [7:0] d;
        d = {7'((p * 37 + b * 11) ^ 7'h55), 1'((p >> b) & 1)};
        bank_write(d);
      end
      check("R4 model", 32'(model), 32'(p));
      access(1'b1, 1'b0, 15'h0000, 8'h00, "R4 base");
      check("R4 base value", 32'(mb_addr), 32'(p) << 15);
      access(1'b0, 1'b1, 15'h7FFF, 8'(p), "R5 top offset");
      access(1'b1, 1'b1, 15'(p * 71), 8'(p ^ 8'hA5), "R5 mixed offset");
    end

    // R7 access in the same cycle as a bank write uses the old base
    @(negedge clk);
    bank_we = 1'b1; bank_wdata = {7'h00, ~model[0]};
    win_rd = 1'b1; win_off = 15'h0042;
    @(negedge clk);
    check("R7 old base", 32'(mb_addr), 32'(exp_addr(15'h0042)));
    bank_we = 1'b0; win_rd = 1'b0;
    model = {bank_wdata[0], model[8:1]};
    access(1'b1, 1'b0, 15'h0042, 8'h00, "R7 new base after");

    // R8 idle cycles hold address and drop strobes
    held = mb_addr;
    for (int i = 0; i < 3; i++) begin
      if (i == 1) bank_write(8'h01);
      else @(negedge clk);
      check("R8 rd low", {31'd0, mb_rd}, 32'd0);
      check("R8 wr low", {31'd0, mb_wr}, 32'd0);
      check("R8 addr held", 32'(mb_addr), 32'(held));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule